// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block tracks one address reservation for each hardware thread context so that a core can implement atomic read-modify-write sequences with a locked load followed by a conditional store. Each cycle it may receive one memory request: a context index, a physical address, and flags saying whether the access is locked, whether it is a store, and whether it is uncacheable. A locked load records a reservation for its context. A conditional store is judged against that reservation and answered with a result code one cycle later. Ordinary stores and conditional stores that write memory remove every reservation that covers the written location, whichever context owns it.

Reservations compare addresses on aligned granules of 2^GRAN_BITS bytes, 16 bytes by default. Each context also counts its consecutive conditional-store failures. Each time the count reaches a multiple of WARN_EVERY, the block raises a one-cycle warning naming the context, which flags a possible livelock. The count saturates at its maximum and does not wrap. Memory access, caching and coherence messages are handled elsewhere.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `lock_flags` is all zero and `rsp_valid` and `warn` are 0.
- R2: A locked load (`req_valid`=1, `req_locked`=1, `req_store`=0) sets bit `req_ctx` of `lock_flags` in the next cycle and records the address's granule for that context.
- R3: A cacheable conditional store (`req_valid`, `req_locked`, `req_store` all 1, `req_uncached`=0) whose context holds a reservation on the same granule (address bits above GRAN_BITS equal) answers `rsp_code`=1 in the next cycle.
- R4: A cacheable conditional store without such a reservation answers `rsp_code`=0, clears its own context's lock flag, and leaves the other contexts' flags unchanged.
- R5: An uncacheable conditional store answers `rsp_code`=2 whatever the reservation state, and it clears reservations on the written granule as a successful one does.
- R6: A successful or uncacheable conditional store, or an ordinary store (`req_store`=1, `req_locked`=0), clears the lock flag of every context whose reserved granule equals the written one. Reservations on other granules are kept.
- R7: An ordinary load, or a cycle with `req_valid`=0, changes no lock flag and produces no response.
- R8: `rsp_valid` is 1 for exactly one cycle, the cycle after each conditional store, and is 0 in every other cycle. The code value 3 never appears.
- R9: Each failing conditional store adds one to its context's failure count. When the new count is a nonzero multiple of WARN_EVERY, `warn` pulses with `warn_ctx` set to the context, in the same cycle as the response.
- R10: A code-1 or code-2 answer resets that context's failure count to zero. Other contexts' counts are unchanged.
- R11: The failure count saturates at 2^CNT_W-1. Further failures leave it there and raise no warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ctx | input | CW | Issuing context index |
| req_addr | input | AW | Physical byte address |
| req_locked | input | 1 | Locked load, or conditional store |
| req_store | input | 1 | Request writes memory |
| req_uncached | input | 1 | Target is uncacheable |
| rsp_valid | output | 1 | Conditional-store result is present |
| rsp_code | output | 2 | 0 fail, 1 success, 2 uncacheable |
| lock_flags | output | NCTX | Reservation-held flag per context |
| warn | output | 1 | Livelock warning pulse |
| warn_ctx | output | CW | Context named by the warning |

## Verification
The bench builds the block with 4 contexts, a 12-bit address, 16-byte granules, WARN_EVERY=3 and a 3-bit failure counter. This makes the warning period a handful of requests and puts saturation at 7, so the bench reaches warnings at counts 3 and 6 and shows that none comes at 9. Several thousand mixed requests are drawn from six addresses that fall into three granules. This produces same-granule and cross-context collisions often, and a bench reference model checks every cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        SC_FAIL     = 2'd0,
        SC_OK       = 2'd1,
        SC_UNCACHED = 2'd2
    } sc_code_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_LOCKED_LOAD,
        OP_COND_STORE,
        OP_STORE
    } req_op_e;

    function automatic req_op_e classify(input logic valid,
                                         input logic locked,
                                         input logic store);
        if (!valid)              return OP_IDLE;
        else if (locked && store) return OP_COND_STORE;
        else if (locked)          return OP_LOCKED_LOAD;
        else if (store)           return OP_STORE;
        else                      return OP_LOAD;
    endfunction

endpackage

// File: rtl/rsv_slot.sv
module rsv_slot #(
    parameter int AW        = 32,
    parameter int GRAN_BITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_lock,
    input  logic                    drop_own,
    input  logic                    snoop_en,
    input  logic [AW-GRAN_BITS-1:0] req_tag,
    output logic                    held,
    output logic                    tag_hit
);
    localparam int TW = AW - GRAN_BITS;

    typedef struct packed {
        logic          flag;
        logic [TW-1:0] tag;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  same_gran;

    always_comb begin
        same_gran = (slot_q.tag == req_tag);
        slot_d    = slot_q;
        if (set_lock) begin
            slot_d.flag = 1'b1;
            slot_d.tag  = req_tag;
        end else if (drop_own) begin
            slot_d.flag = 1'b0;
        end else if (snoop_en && same_gran) begin
            slot_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign held    = slot_q.flag;
    assign tag_hit = slot_q.flag && same_gran;

endmodule

// File: rtl/fail_tracker.sv
module fail_tracker #(
    parameter int CNT_W      = 32,
    parameter int WARN_EVERY = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    input  logic clear,
    output logic warn_now
);
    localparam int PW = (WARN_EVERY > 2) ? $clog2(WARN_EVERY) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [PW-1:0]    PH_LAST = PW'(WARN_EVERY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    phase;
    } trk_t;

    trk_t trk_d, trk_q;
    logic can_bump;

    always_comb begin
        trk_d    = trk_q;
        can_bump = bump && (trk_q.cnt != CNT_MAX);
        warn_now = can_bump && (trk_q.phase == PH_LAST);
        if (clear) begin
            trk_d = '0;
        end else if (can_bump) begin
            trk_d.cnt   = trk_q.cnt + 1'b1;
            trk_d.phase = (trk_q.phase == PH_LAST) ? '0 : trk_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NCTX       = 4,
    parameter int AW         = 32,
    parameter int GRAN_BITS  = 4,
    parameter int WARN_EVERY = 100000,
    parameter int CNT_W      = 32,
    localparam int CW        = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [CW-1:0]   req_ctx,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_locked,
    input  logic            req_store,
    input  logic            req_uncached,
    output logic            rsp_valid,
    output logic [1:0]      rsp_code,
    output logic [NCTX-1:0] lock_flags,
    output logic            warn,
    output logic [CW-1:0]   warn_ctx
);
    localparam int TW = AW - GRAN_BITS;

    typedef struct packed {
        logic          valid;
        sc_code_e      code;
        logic          warn;
        logic [CW-1:0] wctx;
    } out_t;

    out_t            out_d, out_q;
    req_op_e         op;
    logic [TW-1:0]   req_tag;
    logic [NCTX-1:0] sel;
    logic [NCTX-1:0] hit_vec;
    logic [NCTX-1:0] held_vec;
    logic [NCTX-1:0] warn_vec;
    logic [NCTX-1:0] set_vec;
    logic [NCTX-1:0] drop_vec;
    logic [NCTX-1:0] bump_vec;
    logic [NCTX-1:0] clr_vec;
    logic            own_hit;
    logic            sc_pass;
    logic            sc_fail;
    logic            sc_unc;
    logic            snoop_en;

    always_comb begin
        op      = classify(req_valid, req_locked, req_store);
        req_tag = req_addr[AW-1:GRAN_BITS];
        for (int i = 0; i < NCTX; i++) sel[i] = (req_ctx == CW'(i));
        own_hit  = |(hit_vec & sel);
        sc_unc   = (op == OP_COND_STORE) && req_uncached;
        sc_pass  = (op == OP_COND_STORE) && !req_uncached && own_hit;
        sc_fail  = (op == OP_COND_STORE) && !req_uncached && !own_hit;
        snoop_en = (op == OP_STORE) || sc_pass || sc_unc;
        set_vec  = (op == OP_LOCKED_LOAD) ? sel : '0;
        drop_vec = sc_fail ? sel : '0;
        bump_vec = sc_fail ? sel : '0;
        clr_vec  = (sc_pass || sc_unc) ? sel : '0;

        out_d.valid = (op == OP_COND_STORE);
        out_d.code  = sc_unc ? SC_UNCACHED : (sc_pass ? SC_OK : SC_FAIL);
        out_d.warn  = |warn_vec;
        out_d.wctx  = req_ctx;
    end

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        rsv_slot #(
            .AW        (AW),
            .GRAN_BITS (GRAN_BITS)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_lock (set_vec[g]),
            .drop_own (drop_vec[g]),
            .snoop_en (snoop_en),
            .req_tag  (req_tag),
            .held     (held_vec[g]),
            .tag_hit  (hit_vec[g])
        );

        fail_tracker #(
            .CNT_W      (CNT_W),
            .WARN_EVERY (WARN_EVERY)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .bump     (bump_vec[g]),
            .clear    (clr_vec[g]),
            .warn_now (warn_vec[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid  = out_q.valid;
    assign rsp_code   = out_q.code;
    assign warn       = out_q.warn;
    assign warn_ctx   = out_q.wctx;
    assign lock_flags = held_vec;

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int NCTX = 4,
    parameter int AW   = 32,
    parameter int CW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [CW-1:0]   req_ctx,
    input logic [AW-1:0]   req_addr,
    input logic            req_locked,
    input logic            req_store,
    input logic            req_uncached,
    input logic            rsp_valid,
    input logic [1:0]      rsp_code,
    input logic [NCTX-1:0] lock_flags,
    input logic            warn,
    input logic [CW-1:0]   warn_ctx
);
    logic is_sc;
    assign is_sc = req_valid && req_locked && req_store;

    a_r8_rsp_follows_sc: assert property (@(posedge clk) disable iff (!rst_n)
        is_sc |=> rsp_valid);

    a_r8_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !is_sc |=> !rsp_valid);

    a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code != 2'd3);

    a_r5_uncached_code: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && req_uncached) |=> rsp_code == 2'd2);

    a_r2_ll_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_locked && !req_store) |=> lock_flags[$past(req_ctx)]);

    a_r4_fail_drops_own: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd0) |-> !lock_flags[$past(req_ctx)]);

    a_r7_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || (!req_locked && !req_store)) |=> $stable(lock_flags));

    a_r9_warn_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> (rsp_valid && rsp_code == 2'd0));

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .NCTX (NCTX),
    .AW   (AW),
    .CW   (CW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ctx      (req_ctx),
    .req_addr     (req_addr),
    .req_locked   (req_locked),
    .req_store    (req_store),
    .req_uncached (req_uncached),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .lock_flags   (lock_flags),
    .warn         (warn),
    .warn_ctx     (warn_ctx)
);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
    localparam int NCTX = 4;
    localparam int AW   = 12;
    localparam int CW   = 2;
    localparam int WE   = 3;
    localparam int CMAX = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [CW-1:0]   req_ctx = '0;
    logic [AW-1:0]   req_addr = '0;
    logic            req_locked = 1'b0;
    logic            req_store = 1'b0;
    logic            req_uncached = 1'b0;
    logic            rsp_valid;
    logic [1:0]      rsp_code;
    logic [NCTX-1:0] lock_flags;
    logic            warn;
    logic [CW-1:0]   warn_ctx;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    bit        mflag [NCTX];
    bit [7:0]  mgran [NCTX];
    int        mcnt  [NCTX];

    always #10 clk = ~clk;

    llsc_monitor #(
        .NCTX(NCTX), .AW(AW), .GRAN_BITS(4), .WARN_EVERY(WE), .CNT_W(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_addr(req_addr), .req_locked(req_locked), .req_store(req_store),
        .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .lock_flags(lock_flags), .warn(warn), .warn_ctx(warn_ctx)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One request; model computes expected from requirements; checked at next negedge.
    task automatic step(input bit v, input int c, input int a,
                        input bit lk, input bit st, input bit un);
        bit     hit, is_sc, is_ll, is_st, pass, wexp;
        int     code;
        int     efl;
        string  ftag;
        hit   = mflag[c] && (mgran[c] == a[11:4]);
        is_sc = v && lk && st;
        is_ll = v && lk && !st;
        is_st = v && !lk && st;
        pass  = is_sc && !un && hit;
        code  = (is_sc && un) ? 2 : (pass ? 1 : 0);
        wexp  = 0;
        ftag  = is_ll ? "R2" : ((is_st || pass || (is_sc && un)) ? "R6" :
                (is_sc ? "R4" : "R7"));
        if (is_ll) begin
            mflag[c] = 1; mgran[c] = a[11:4];
        end else if (is_sc && !un && !hit) begin
            mflag[c] = 0;
            if (mcnt[c] < CMAX) begin
                mcnt[c]++;
                wexp = (mcnt[c] % WE) == 0;
            end
        end
        if (is_sc && (un || pass)) mcnt[c] = 0;
        if (is_st || pass || (is_sc && un))
            for (int i = 0; i < NCTX; i++)
                if (mgran[i] == a[11:4]) mflag[i] = 0;
        efl = 0;
        for (int i = 0; i < NCTX; i++) efl |= int'(mflag[i]) << i;

        req_valid = v; req_ctx = CW'(c); req_addr = AW'(a);
        req_locked = lk; req_store = st; req_uncached = un;
        @(posedge clk);
        @(negedge clk);
        nvec++;
        cmp("R8 rsp_valid", int'(rsp_valid), int'(is_sc));
        if (is_sc) cmp(un ? "R5 code" : (pass ? "R3 code" : "R4 code"),
                       int'(rsp_code), code);
        cmp({ftag, " lock_flags"}, int'(lock_flags), efl);
        cmp((mcnt[c] == CMAX && !wexp && is_sc) ? "R11 warn" : "R9 warn",
            int'(warn), int'(wexp));
        if (wexp) cmp("R9 warn_ctx", int'(warn_ctx), c);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int addrs [6] = '{12'h100, 12'h104, 12'h10F, 12'h110, 12'h11C, 12'h200};
        for (int i = 0; i < NCTX; i++) begin
            mflag[i] = 0; mgran[i] = 0; mcnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        nvec++;
        cmp("R1 flags", int'(lock_flags), 0);
        cmp("R1 rsp_valid", int'(rsp_valid), 0);
        cmp("R1 warn", int'(warn), 0);
        rst_n = 1'b1;
        @(negedge clk);
        nvec++;
        cmp("R1 flags after release", int'(lock_flags), 0);

        // R3: reserve then succeed within the same granule
        step(1, 0, 12'h120, 1, 0, 0);
        step(1, 0, 12'h12C, 1, 1, 0);
        // R4: mismatched granule fails, other contexts untouched
        step(1, 1, 12'h300, 1, 0, 0);
        step(1, 2, 12'h400, 1, 0, 0);
        step(1, 1, 12'h310, 1, 1, 0);
        // R6: ordinary store from another context kills ctx2 reservation
        step(1, 3, 12'h40A, 0, 1, 0);
        // R5: uncacheable store-conditional with no reservation
        step(1, 3, 12'h500, 1, 1, 1);
        // R7: plain load and idle leave flags alone
        step(1, 0, 12'h200, 1, 0, 0);
        step(1, 1, 12'h200, 0, 0, 0);
        step(0, 2, 12'h200, 1, 1, 0);
        // R9/R11: long failure streak on ctx3; warns at 3 and 6, none at 9
        for (int k = 0; k < 10; k++) step(1, 3, 12'h600, 1, 1, 0);
        // R10: uncacheable answer resets count; three more fails warn again
        step(1, 3, 12'h600, 1, 1, 1);
        for (int k = 0; k < 3; k++) step(1, 3, 12'h600, 1, 1, 0);

        // near-exhaustive mixed sweep
        for (int n = 0; n < 6000; n++) begin
            int  r  = $urandom_range(0, 9);
            int  c  = $urandom_range(0, NCTX - 1);
            int  a  = addrs[$urandom_range(0, 5)];
            bit  v  = (r != 0);
            bit  lk = (r < 7);
            bit  st = (r >= 4);
            bit  un = ($urandom_range(0, 7) == 0);
            step(v, c, a, lk, st, un);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule